// File: doc/BRIEF.md
# Dual-Identity I2C Memory and Register Target

This block is an I2C target built around two identities that share one set of device-select pins. The upper nibble of the address byte picks one of two spaces. One space is a byte-wide memory with a 13-bit address. The other is a small register space that holds a writable memory control byte, an eight-byte serial number, a four-byte device identifier and a writable command byte. The target acknowledges only address bytes that match one of its two identities and its select pins. It takes the address for the chosen space and then moves data bytes in either direction. The address advances after every byte.

The block works from SCL and SDA sampled in the system clock domain. It drives SDA through an active-high pull-low enable, and the board provides the pull-up. The memory address path is always 13 bits wide. The storage behind it has a parameterised depth and is indexed by the low address bits, so small configurations alias the upper addresses onto the same storage. The serial number and device identifier are fixed by parameters.

Top module: `i2c_dual_target`

## Requirements
- R1: In the first byte after a START, bits [7:1] are the target address and bit 0 is the direction: 1 means read, 0 means write. When a read-direction address matches, the target drives a data byte right after its acknowledge.
- R2: Address bits [7:4] = 1010b select the memory space and 0011b select the register space. Any other upper nibble is not acknowledged.
- R3: Address bits [3:1] must equal `dev_sel[2:0]`. When `TWO_PIN_SEL` = 1, only bits [3:2] are compared, against `dev_sel[2:1]`, and bit 1 is a don't-care.
- R4: A non-matching address byte gets no acknowledge, and SDA is not driven again until the next START or STOP. After reset and while idle, SDA is released.
- R5: A write-direction memory access is followed by two address bytes, high byte first. Bits [7:5] of the high byte are ignored.
- R6: Each accepted address, offset or data byte is acknowledged by holding SDA low during the ninth clock.
- R7: The memory address advances by one after each data byte, read or written, and steps from 0x1FFF to 0x0000.
- R8: The register space takes a single offset byte. Offset 0x00 is memory control, 0x01–0x08 is the serial number (most significant byte first), 0x09–0x0C is the device identifier (most significant byte first) and 0x0D is the command byte. Every other offset reads 0x00.
- R9: Writes to the serial number and identifier offsets leave them unchanged. Memory control and command take written values and read them back, and both reset to 0x00.
- R10: The register pointer advances after each data byte and steps from 0x0D, or from any offset above it, to 0x00.
- R11: A read, whether after a repeated START or a fresh START, continues from the current address of the selected space.
- R12: When the master NACKs a read byte, the target releases SDA and sends nothing more until the next START or STOP.
- R13: The SDA enable changes only while SCL is low. A START restarts address reception, even in the middle of a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| dev_sel | input | 3 | Device-select straps compared with address bits [3:1] |
| sda_oe | output | 1 | When 1, the pin pulls SDA low |

## Verification
The bench tries every upper nibble with every select code on two instances that share the bus. One instance compares three select bits and the other compares two. A wrong nibble or select comparison shows up as an acknowledge on the wrong byte, or as two targets answering together. It writes across the 0x1FFF boundary and sets high-byte bits that must be ignored. A missing wrap or a used top bit makes the read-back return data from the wrong location. In the register space it reads all fourteen offsets in one burst, writes the read-only bytes, and walks the pointer past 0x0D. A design that stores into the serial number, skips the wrap, or returns stale data for unmapped offsets fails there. A START in the middle of a byte and clocks sent after a NACK or after a mismatch check that the target restarts cleanly and stays off the line.

// File: rtl/i2c_dual_pkg.sv
package i2c_dual_pkg;

    localparam logic [3:0] ID_MEM = 4'b1010;
    localparam logic [3:0] ID_REG = 4'b0011;

    localparam int SER_BYTES = 8;
    localparam int DID_BYTES = 4;

    localparam logic [7:0] OFF_MCTL = 8'h00;
    localparam logic [7:0] OFF_SER0 = OFF_MCTL + 8'd1;
    localparam logic [7:0] OFF_DID0 = OFF_SER0 + 8'(SER_BYTES);
    localparam logic [7:0] OFF_CMD  = OFF_DID0 + 8'(DID_BYTES);
    localparam logic [7:0] OFF_LAST = OFF_CMD;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } state_e;

    typedef enum logic [2:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_OFF,
        K_DATA
    } kind_e;

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    typedef struct packed {
        logic scl_m;
        logic scl_s;
        logic scl_p;
        logic sda_m;
        logic sda_s;
        logic sda_p;
    } smp_t;

    smp_t q, d;

    always_comb begin
        d       = q;
        d.scl_m = scl_i;
        d.scl_s = q.scl_m;
        d.scl_p = q.scl_s;
        d.sda_m = sda_i;
        d.sda_s = q.sda_m;
        d.sda_p = q.sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_s     = q.sda_s;
    assign scl_rise  = q.scl_s & ~q.scl_p;
    assign scl_fall  = ~q.scl_s & q.scl_p;
    assign bus_start = q.scl_s & q.scl_p & q.sda_p & ~q.sda_s;
    assign bus_stop  = q.scl_s & q.scl_p & ~q.sda_p & q.sda_s;

endmodule

// File: rtl/i2c_reg_space.sv
module i2c_reg_space
    import i2c_dual_pkg::*;
#(
    parameter logic [8*SER_BYTES-1:0] SER_NUM = 64'h1122_3344_5566_7788,
    parameter logic [8*DID_BYTES-1:0] DEV_ID  = 32'hD00A_513C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] waddr,
    input  logic [7:0] wdata,
    input  logic [7:0] raddr,
    output logic [7:0] rdata
);

    typedef struct packed {
        logic [7:0] mctl;
        logic [7:0] cmd;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (we && waddr == OFF_MCTL) d.mctl = wdata;
        if (we && waddr == OFF_CMD)  d.cmd  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = 8'h00;
        if (raddr == OFF_MCTL) rdata = q.mctl;
        if (raddr == OFF_CMD)  rdata = q.cmd;
        for (int k = 0; k < SER_BYTES; k++) begin
            if (raddr == OFF_SER0 + 8'(k)) rdata = SER_NUM[8*(SER_BYTES-k)-1 -: 8];
        end
        for (int k = 0; k < DID_BYTES; k++) begin
            if (raddr == OFF_DID0 + 8'(k)) rdata = DEV_ID[8*(DID_BYTES-k)-1 -: 8];
        end
    end

endmodule

// File: rtl/i2c_byte_store.sv
module i2c_byte_store #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_dual_target.sv
module i2c_dual_target
    import i2c_dual_pkg::*;
#(
    parameter int                     MEM_AW      = 13,
    parameter int                     STORE_AW    = 10,
    parameter bit                     TWO_PIN_SEL = 1'b0,
    parameter logic [8*SER_BYTES-1:0] SER_NUM     = 64'h1122_3344_5566_7788,
    parameter logic [8*DID_BYTES-1:0] DEV_ID      = 32'hD00A_513C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel,
    output logic       sda_oe
);

    localparam int HI_W = MEM_AW - 8;

    typedef struct packed {
        state_e            st;
        kind_e             kind;
        logic [3:0]        bitcnt;
        logic [7:0]        sh;
        logic              is_reg;
        logic              rd;
        logic [MEM_AW-1:0] maddr;
        logic [7:0]        cptr;
        logic              oe;
    } ctl_t;

    ctl_t q, d;

    logic       sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic       mem_we, reg_we;
    logic [7:0] mem_rdata, reg_rdata, tx_byte;
    logic       hit_mem, hit_reg, sel_ok;

    i2c_bus_sampler u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_byte_store #(.AW(STORE_AW), .DW(8)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (q.maddr[STORE_AW-1:0]),
        .wdata (q.sh),
        .raddr (q.maddr[STORE_AW-1:0]),
        .rdata (mem_rdata)
    );

    i2c_reg_space #(.SER_NUM(SER_NUM), .DEV_ID(DEV_ID)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (q.cptr),
        .wdata (q.sh),
        .raddr (q.cptr),
        .rdata (reg_rdata)
    );

    assign tx_byte = q.is_reg ? reg_rdata : mem_rdata;
    assign hit_mem = (q.sh[7:4] == ID_MEM);
    assign hit_reg = (q.sh[7:4] == ID_REG);
    assign sel_ok  = TWO_PIN_SEL ? (q.sh[3:2] == dev_sel[2:1]) : (q.sh[3:1] == dev_sel);

    function automatic logic [7:0] cptr_next(input logic [7:0] p);
        return (p >= OFF_LAST) ? 8'h00 : p + 8'd1;
    endfunction

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        reg_we = 1'b0;

        if (bus_stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (bus_start) begin
            d.st     = ST_RX;
            d.kind   = K_DEV;
            d.bitcnt = 4'd0;
            d.oe     = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise && q.bitcnt < 4'd8) begin
                        d.sh     = {q.sh[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        d.st = ST_ACK;
                        d.oe = 1'b1;
                        unique case (q.kind)
                            K_DEV: begin
                                if ((hit_mem || hit_reg) && sel_ok) begin
                                    d.is_reg = hit_reg;
                                    d.rd     = q.sh[0];
                                    d.kind   = q.sh[0] ? K_DATA : (hit_reg ? K_OFF : K_AHI);
                                end else begin
                                    d.st = ST_IGNORE;
                                    d.oe = 1'b0;
                                end
                            end
                            K_AHI: begin
                                d.maddr[MEM_AW-1:8] = q.sh[HI_W-1:0];
                                d.kind              = K_ALO;
                            end
                            K_ALO: begin
                                d.maddr[7:0] = q.sh;
                                d.kind       = K_DATA;
                            end
                            K_OFF: begin
                                d.cptr = q.sh;
                                d.kind = K_DATA;
                            end
                            default: begin
                                if (q.is_reg) begin
                                    reg_we = 1'b1;
                                    d.cptr = cptr_next(q.cptr);
                                end else begin
                                    mem_we  = 1'b1;
                                    d.maddr = q.maddr + MEM_AW'(1);
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.bitcnt = 4'd0;
                        if (q.rd) begin
                            d.st = ST_TX;
                            d.sh = tx_byte;
                            d.oe = ~tx_byte[7];
                            if (q.is_reg) d.cptr  = cptr_next(q.cptr);
                            else          d.maddr = q.maddr + MEM_AW'(1);
                        end else begin
                            d.st = ST_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                        d.sh     = {q.sh[6:0], 1'b0};
                        if (q.bitcnt == 4'd7) begin
                            d.st = ST_MACK;
                            d.oe = 1'b0;
                        end else begin
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise && sda_s) begin
                        d.st = ST_IGNORE;
                    end else if (scl_fall) begin
                        d.st     = ST_TX;
                        d.bitcnt = 4'd0;
                        d.sh     = tx_byte;
                        d.oe     = ~tx_byte[7];
                        if (q.is_reg) d.cptr  = cptr_next(q.cptr);
                        else          d.maddr = q.maddr + MEM_AW'(1);
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.kind   <= K_DEV;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;

endmodule

// File: rtl/i2c_dual_chk.sv
module i2c_dual_chk
    import i2c_dual_pkg::*;
#(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe,
    input state_e        st,
    input logic          bus_start,
    input logic          mem_we,
    input logic          reg_we,
    input logic [AW-1:0] maddr,
    input logic [7:0]    cptr
);

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i); // R13

    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (st == ST_RX)); // R13

    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE) |-> !sda_oe); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe); // R4

    AST_MEM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && maddr == '1) |=> (maddr == '0)); // R7

    AST_MEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && maddr != '1) |=> (maddr == $past(maddr) + AW'(1))); // R7

    AST_REG_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && cptr >= OFF_LAST) |=> (cptr == 8'h00)); // R10

    AST_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && reg_we)); // R2

endmodule

bind i2c_dual_target i2c_dual_chk #(.AW(MEM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .st        (q.st),
    .bus_start (bus_start),
    .mem_we    (mem_we),
    .reg_we    (reg_we),
    .maddr     (q.maddr),
    .cptr      (q.cptr)
);

// File: tb/sim_i2c_dual_target.sv
module sim_i2c_dual_target;

    localparam int HP = 10;
    localparam logic [63:0] SER = 64'hA1B2_C3D4_E5F6_0718;
    localparam logic [31:0] DID = 32'h5E0C_77A9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic oe0, oe1;
    logic sda_line;
    int   n_chk = 0;
    int   n_bad = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~oe0 & ~oe1;

    i2c_dual_target #(.TWO_PIN_SEL(1'b0), .SER_NUM(SER), .DEV_ID(DID)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .dev_sel(3'b101), .sda_oe(oe0));

    i2c_dual_target #(.TWO_PIN_SEL(1'b1), .SER_NUM(SER), .DEV_ID(DID)) u1 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .dev_sel(3'b010), .sda_oe(oe1));

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bstart();
        sda_m = 1'b1; wt(HP/2);
        scl_m = 1'b1; wt(HP);
        sda_m = 1'b0; wt(HP);
        scl_m = 1'b0; wt(HP/2);
    endtask

    task automatic bstop();
        sda_m = 1'b0; wt(HP/2);
        scl_m = 1'b1; wt(HP);
        sda_m = 1'b1; wt(HP);
    endtask

    task automatic wb_raw(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(HP/2);
            scl_m = 1'b1; wt(HP);
            scl_m = 1'b0; wt(HP/2);
        end
        sda_m = 1'b1; wt(HP/2);
        scl_m = 1'b1; wt(HP/2);
        ack = ~sda_line;
        wt(HP/2);
        scl_m = 1'b0; wt(HP/2);
    endtask

    task automatic wb(input logic [7:0] b);
        logic a;
        wb_raw(b, a);
        check("R6 ack of accepted byte", {7'd0, a}, 8'd1);
    endtask

    task automatic rb(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(HP/2);
            scl_m = 1'b1; wt(HP/2);
            b[i] = sda_line;
            wt(HP/2);
            scl_m = 1'b0;
        end
        wt(HP/2);
        sda_m = nack; wt(HP/2);
        scl_m = 1'b1; wt(HP);
        scl_m = 1'b0; wt(HP/2);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] reg_exp(input int off, input logic [7:0] mctl, input logic [7:0] cmd);
        if (off == 0) return mctl;
        if (off >= 1 && off <= 8) return SER[8*(9-off)-1 -: 8];
        if (off >= 9 && off <= 12) return DID[8*(13-off)-1 -: 8];
        if (off == 13) return cmd;
        return 8'h00;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic       a;
        logic [7:0] b;
        wt(8);
        rst_n = 1'b1;
        wt(8);
        check("R4 SDA released after reset", {7'd0, sda_line}, 8'd1);

        // R2 R3: every upper nibble against every select code, both instances
        for (int nib = 0; nib < 16; nib++) begin
            for (int sel = 0; sel < 8; sel++) begin
                logic [7:0] ab;
                logic       exp;
                ab  = {4'(nib), 3'(sel), 1'b0};
                exp = (nib == 4'hA || nib == 4'h3) &&
                      (sel == 5 || (sel >> 1) == 1);
                bstart();
                wb_raw(ab, a);
                bstop();
                check($sformatf("R2 R3 ack for address byte %h", ab), {7'd0, a}, {7'd0, exp});
            end
        end

        // R5: high address bits 7..5 ignored; R7 increment on write
        bstart(); wb(8'hAA); wb(8'hE1); wb(8'h23);
        for (int i = 0; i < 5; i++) wb(8'(8'h30 + 5*i));
        bstop();
        // R11: repeated START read continues from set address; R1 read direction
        bstart(); wb(8'hAA); wb(8'h01); wb(8'h23);
        bstart(); wb(8'hAB);
        for (int i = 0; i < 4; i++) begin
            rb(i == 3, b);
            check("R5 R1 read back of written byte", b, 8'(8'h30 + 5*i));
        end
        bstop();
        bstart(); wb(8'hAB); rb(1'b1, b);
        check("R11 fresh read continues at current address", b, 8'h44);
        // R12: after NACK no further data is driven
        rb(1'b1, b);
        check("R12 line idle after NACK", b, 8'hFF);
        bstop();

        // R7: wrap across the top of the address range
        bstart(); wb(8'hAA); wb(8'h1F); wb(8'hFF); wb(8'h5A); wb(8'hC3); bstop();
        bstart(); wb(8'hAA); wb(8'h00); wb(8'h00);
        bstart(); wb(8'hAB); rb(1'b1, b); bstop();
        check("R7 byte after 0x1FFF lands at 0x0000", b, 8'hC3);
        bstart(); wb(8'hAA); wb(8'h3F); wb(8'hFF);
        bstart(); wb(8'hAB);
        rb(1'b0, b); check("R7 R5 byte at 0x1FFF", b, 8'h5A);
        rb(1'b1, b); check("R7 read wraps to 0x0000", b, 8'hC3);
        bstop();

        // R7: long burst with arithmetic pattern
        bstart(); wb(8'hAA); wb(8'h0A); wb(8'h00);
        for (int i = 0; i < 48; i++) wb(8'((i*37 + 11) & 8'hFF));
        bstop();
        bstart(); wb(8'hAA); wb(8'h0A); wb(8'h00);
        bstart(); wb(8'hAB);
        for (int i = 0; i < 48; i++) begin
            rb(i == 47, b);
            check("R7 burst read-back", b, 8'((i*37 + 11) & 8'hFF));
        end
        bstop();

        // R8 R10: register space full sweep with wrap
        bstart(); wb(8'h3A); wb(8'h00); wb(8'h5C); bstop();
        bstart(); wb(8'h3A); wb(8'h00);
        bstart(); wb(8'h3B);
        for (int i = 0; i < 15; i++) begin
            rb(i == 14, b);
            check($sformatf("R8 R10 register offset %0d", i % 14), b, reg_exp(i % 14, 8'h5C, 8'h00));
        end
        bstop();

        // R9: read-only bytes unchanged, command writable, R10 wrap on write
        bstart(); wb(8'h3A); wb(8'h03); wb(8'hFF); wb(8'hFF); bstop();
        bstart(); wb(8'h3A); wb(8'h0A); wb(8'h00); bstop();
        bstart(); wb(8'h3A); wb(8'h0D); wb(8'h99); wb(8'h11); bstop();
        bstart(); wb(8'h3A); wb(8'h03);
        bstart(); wb(8'h3B);
        rb(1'b0, b); check("R9 serial byte 3 read-only", b, reg_exp(3, 8'h11, 8'h99));
        rb(1'b1, b); check("R9 serial byte 4 read-only", b, reg_exp(4, 8'h11, 8'h99));
        bstop();
        bstart(); wb(8'h3A); wb(8'h0A);
        bstart(); wb(8'h3B); rb(1'b1, b); bstop();
        check("R9 identifier byte read-only", b, reg_exp(10, 8'h11, 8'h99));
        bstart(); wb(8'h3A); wb(8'h0D);
        bstart(); wb(8'h3B);
        rb(1'b0, b); check("R9 command byte written", b, 8'h99);
        rb(1'b1, b); check("R10 write wrapped into memory control", b, 8'h11);
        bstop();
        bstart(); wb(8'h3A); wb(8'h20);
        bstart(); wb(8'h3B);
        rb(1'b0, b); check("R8 unmapped offset reads zero", b, 8'h00);
        rb(1'b1, b); check("R10 pointer past last offset wraps", b, 8'h11);
        bstop();

        // R13: START in the middle of a byte restarts reception
        bstart();
        for (int i = 0; i < 3; i++) begin
            sda_m = i[0]; wt(HP/2);
            scl_m = 1'b1; wt(HP);
            scl_m = 1'b0; wt(HP/2);
        end
        bstart(); wb(8'hAA); wb(8'h01); wb(8'h23);
        bstart(); wb(8'hAB); rb(1'b1, b); bstop();
        check("R13 transfer after mid-byte START", b, 8'h30);

        // R3: two-pin instance answers on both values of the don't-care bit
        bstart(); wb(8'hA6); wb(8'h00); wb(8'h10); wb(8'h77); wb(8'h88); bstop();
        bstart(); wb(8'hA4); wb(8'h00); wb(8'h10);
        bstart(); wb(8'hA5);
        rb(1'b0, b); check("R3 two-pin select, first byte", b, 8'h77);
        rb(1'b1, b); check("R3 two-pin select, second byte", b, 8'h88);
        bstop();

        // R4: mismatched address is never acknowledged, later bytes ignored
        bstart();
        wb_raw(8'hA0, a); check("R4 no ack on mismatch", {7'd0, a}, 8'd0);
        wb_raw(8'h00, a); check("R4 ignored after mismatch", {7'd0, a}, 8'd0);
        bstop();
        check("R4 SDA released when idle", {7'd0, sda_line}, 8'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule